// File: doc/BRIEF.md
# Dual 40-bit Saturating Accumulator Unit

This block keeps a small bank of 40-bit signed accumulators (two by default) for a 16-bit datapath. Each accumulator holds a 32-bit value plus an 8-bit guard extension, with bit 39 as the sign. Each clock cycle one operation is applied to the accumulator chosen by the select input. The operation can be a single-operand arithmetic step (negate, absolute value, clear), a write from 16-bit register data into a field of the accumulator, or a read of a field onto the read-data outputs.

When the saturation input is high, negate and absolute value clamp their result to the signed 32-bit range, even though storage stays 40 bits wide. The absolute-value operation also reports on a flag output whether it had to negate. Every operation completes in one clock. Read data and the flag are registered and hold their value until the next read or absolute-value operation.

Top module: `dual_acc40`

## Requirements
- R1: After reset every accumulator is zero, the flag output is 0 and both read-data outputs are zero.
- R2: Operation code 1 (clear) sets the selected accumulator to zero.
- R3: Operation code 2 (negate) with saturation off stores the two's complement of the selected accumulator, truncated to 40 bits, so 0x8000000000 negates to itself.
- R4: With saturation on, negate and absolute value first form the 40-bit truncated negation and then clamp it. If bit 39 is 0 and the value exceeds 0x7FFFFFFF the result is 0x007FFFFFFF. If bit 39 is 1 and the value is below -2^31 the result is 0xFF80000000. Any other value is stored unchanged.
- R5: Operation code 3 (absolute value) negates the selected accumulator only when bit 39 is set and then drives flag 1; otherwise the accumulator is unchanged and the flag becomes 0. No other operation changes the flag.
- R6: Operation code 4 (guard write) replaces bits 39:32 with reg_lo_i[7:0] and keeps bits 31:0.
- R7: Operation code 5 (high write) places reg_lo_i, sign-extended to 24 bits, at bits 39:16 and keeps bits 15:0.
- R8: Operation code 6 (low write) loads the whole accumulator with reg_lo_i sign-extended to 40 bits.
- R9: Operation code 7 (pair write) loads the accumulator with {reg_hi_i, reg_lo_i} sign-extended from bit 31.
- R10: Reads leave results on the read outputs one cycle after the operation. Code 8 gives rd_lo_o = bits 39:32 zero-extended. Code 9 gives rd_lo_o = bits 31:16. Code 10 gives rd_lo_o = bits 15:0. For these three codes rd_hi_o is 0. Code 11 gives rd_hi_o = bits 31:16 and rd_lo_o = bits 15:0. Read outputs hold between reads.
- R11: An accumulator that is not selected never changes, and read operations change no accumulator.
- R12: Operation code 0 and codes 12 to 15 change no accumulator, the flag or the read outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code for this cycle |
| sel_i | input | 1 | Accumulator select |
| reg_hi_i | input | 16 | Register data, upper word of a pair |
| reg_lo_i | input | 16 | Register data, single word or lower word of a pair |
| sat_en_i | input | 1 | Saturation mode for negate and absolute value |
| rd_hi_o | output | 16 | Registered read data, upper word |
| rd_lo_o | output | 16 | Registered read data, lower word |
| flag_o | output | 1 | Set when the last absolute value had to negate |
| acc_o | output | 80 | Accumulator contents, accumulator i at bits 40*i+39:40*i |

## Verification
The bench aims at the values where the 40-bit storage and the 32-bit clamp interact. Negating exactly -2^31 must clamp to the positive limit. Negating +2^31 must land on -2^31 with no clamp. The 40-bit minimum negates to itself, and with saturation on it must clamp to the negative limit, not the positive one. A design that clamps before truncating, or that tests the sign of the unwrapped value, flips that last result. The bench also writes the guard and high fields over accumulators holding mixed data. A design that fails to keep the untouched bits, or that zero-extends where it should sign-extend, shows a corrupt accumulator on the next cycle. Random streams check that unused codes and reads leave every accumulator, the flag and the read outputs alone.

// File: rtl/acc40_pkg.sv
`timescale 1ns/1ps
package acc40_pkg;
  parameter int unsigned ACC_W   = 40;
  parameter int unsigned WORD_W  = 16;
  parameter int unsigned PAIR_W  = 2 * WORD_W;
  parameter int unsigned GUARD_W = ACC_W - PAIR_W;
  parameter int unsigned OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 4'd0,
    OP_CLR   = 4'd1,
    OP_NEG   = 4'd2,
    OP_ABS   = 4'd3,
    OP_WGRD  = 4'd4,
    OP_WHI   = 4'd5,
    OP_WLO   = 4'd6,
    OP_WPAIR = 4'd7,
    OP_RGRD  = 4'd8,
    OP_RHI   = 4'd9,
    OP_RLO   = 4'd10,
    OP_RPAIR = 4'd11
  } acc_op_e;

  // two's complement, wraps inside ACC_W bits
  function automatic logic [ACC_W-1:0] twos_neg(input logic [ACC_W-1:0] v);
    return (~v) + {{(ACC_W-1){1'b0}}, 1'b1};
  endfunction

  // clamp to the signed PAIR_W range when enabled
  function automatic logic [ACC_W-1:0] clamp_pair(input logic [ACC_W-1:0] v,
                                                  input logic en);
    logic fits;
    fits = (&v[ACC_W-1:PAIR_W-1]) | ~(|v[ACC_W-1:PAIR_W-1]);
    if (!en || fits) return v;
    if (v[ACC_W-1])
      return {{(GUARD_W+1){1'b1}}, {(PAIR_W-1){1'b0}}};
    return {{(GUARD_W+1){1'b0}}, {(PAIR_W-1){1'b1}}};
  endfunction

  function automatic logic sext_fits_pair(input logic [ACC_W-1:0] v);
    return (v[ACC_W-1:PAIR_W-1] == '0) || (v[ACC_W-1:PAIR_W-1] == '1);
  endfunction

  function automatic logic alters_acc(input acc_op_e op);
    return op inside {OP_CLR, OP_NEG, OP_ABS, OP_WGRD, OP_WHI, OP_WLO, OP_WPAIR};
  endfunction
endpackage

// File: rtl/acc40_alu.sv
`timescale 1ns/1ps
module acc40_alu
  import acc40_pkg::*;
(
  input  acc_op_e          op,
  input  logic             sat_en,
  input  logic [ACC_W-1:0] cur,
  output logic [ACC_W-1:0] res,
  output logic             res_en,
  output logic             flag_val,
  output logic             flag_en
);
  logic [ACC_W-1:0] neg_raw;
  logic             negate_now;

  always_comb begin
    neg_raw    = twos_neg(cur);
    negate_now = (op == OP_NEG) || ((op == OP_ABS) && cur[ACC_W-1]);
    res        = clamp_pair(neg_raw, sat_en);
    res_en     = negate_now;
    flag_en    = (op == OP_ABS);
    flag_val   = cur[ACC_W-1];
  end
endmodule

// File: rtl/acc40_field.sv
`timescale 1ns/1ps
module acc40_field
  import acc40_pkg::*;
(
  input  acc_op_e           op,
  input  logic [ACC_W-1:0]  cur,
  input  logic [WORD_W-1:0] wd_hi,
  input  logic [WORD_W-1:0] wd_lo,
  output logic [ACC_W-1:0]  wr_val,
  output logic              wr_en,
  output logic [WORD_W-1:0] rd_hi,
  output logic [WORD_W-1:0] rd_lo,
  output logic              rd_en
);
  localparam int unsigned HI_EXT = ACC_W - WORD_W - WORD_W;

  always_comb begin
    wr_val = cur;
    wr_en  = 1'b0;
    rd_hi  = '0;
    rd_lo  = '0;
    rd_en  = 1'b0;
    unique case (op)
      OP_WGRD: begin
        wr_val = {wd_lo[GUARD_W-1:0], cur[PAIR_W-1:0]};
        wr_en  = 1'b1;
      end
      OP_WHI: begin
        wr_val = {{HI_EXT{wd_lo[WORD_W-1]}}, wd_lo, cur[WORD_W-1:0]};
        wr_en  = 1'b1;
      end
      OP_WLO: begin
        wr_val = {{(ACC_W-WORD_W){wd_lo[WORD_W-1]}}, wd_lo};
        wr_en  = 1'b1;
      end
      OP_WPAIR: begin
        wr_val = {{GUARD_W{wd_hi[WORD_W-1]}}, wd_hi, wd_lo};
        wr_en  = 1'b1;
      end
      OP_RGRD: begin
        rd_lo = {{(WORD_W-GUARD_W){1'b0}}, cur[ACC_W-1:PAIR_W]};
        rd_en = 1'b1;
      end
      OP_RHI: begin
        rd_lo = cur[PAIR_W-1:WORD_W];
        rd_en = 1'b1;
      end
      OP_RLO: begin
        rd_lo = cur[WORD_W-1:0];
        rd_en = 1'b1;
      end
      OP_RPAIR: begin
        rd_hi = cur[PAIR_W-1:WORD_W];
        rd_lo = cur[WORD_W-1:0];
        rd_en = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_acc40.sv
`timescale 1ns/1ps
module dual_acc40
  import acc40_pkg::*;
#(
  parameter int unsigned NUM_ACC = 2,
  localparam int unsigned SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OP_W-1:0]          op_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [WORD_W-1:0]        reg_hi_i,
  input  logic [WORD_W-1:0]        reg_lo_i,
  input  logic                     sat_en_i,
  output logic [WORD_W-1:0]        rd_hi_o,
  output logic [WORD_W-1:0]        rd_lo_o,
  output logic                     flag_o,
  output logic [NUM_ACC*ACC_W-1:0] acc_o
);
  acc_op_e          op_e;
  logic             sel_ok;
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [ACC_W-1:0] cur;
  logic [ACC_W-1:0] nxt;
  logic             upd;

  // named internal events
  logic [ACC_W-1:0]  alu_res;
  logic              alu_res_en, alu_flag_val, alu_flag_en;
  logic [ACC_W-1:0]  fld_wr_val;
  logic              fld_wr_en, fld_rd_en;
  logic [WORD_W-1:0] fld_rd_hi, fld_rd_lo;

  assign op_e   = acc_op_e'(op_i);
  assign sel_ok = int'(sel_i) < NUM_ACC;
  assign cur    = sel_ok ? acc_q[sel_i] : '0;

  acc40_alu u_alu (
    .op      (op_e),
    .sat_en  (sat_en_i),
    .cur     (cur),
    .res     (alu_res),
    .res_en  (alu_res_en),
    .flag_val(alu_flag_val),
    .flag_en (alu_flag_en)
  );

  acc40_field u_field (
    .op    (op_e),
    .cur   (cur),
    .wd_hi (reg_hi_i),
    .wd_lo (reg_lo_i),
    .wr_val(fld_wr_val),
    .wr_en (fld_wr_en),
    .rd_hi (fld_rd_hi),
    .rd_lo (fld_rd_lo),
    .rd_en (fld_rd_en)
  );

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    if (op_e == OP_CLR) begin
      nxt = '0;
      upd = 1'b1;
    end else if (alu_res_en) begin
      nxt = alu_res;
      upd = 1'b1;
    end else if (fld_wr_en) begin
      nxt = fld_wr_val;
      upd = 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    logic hit;
    assign hit = upd && sel_ok && (int'(sel_i) == i);

    always_ff @(posedge clk) begin
      if (!rst_n)   acc_q[i] <= '0;
      else if (hit) acc_q[i] <= nxt;
    end

    assign acc_o[i*ACC_W +: ACC_W] = acc_q[i];

    // R2: clear leaves zero behind
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_CLR && int'(sel_i) == i) |=> acc_q[i] == '0);

    // R6: guard write keeps the 32-bit body
    assert_guard_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_WGRD && int'(sel_i) == i) |=> acc_q[i][PAIR_W-1:0] == $past(acc_q[i][PAIR_W-1:0]));

    // R4: saturated arithmetic stays in the signed 32-bit range
    assert_sat_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_res_en && sat_en_i && int'(sel_i) == i) |=> sext_fits_pair(acc_q[i]));

    // R11: unselected or non-modifying cycles leave the accumulator alone
    assert_idle_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(int'(sel_i) == i && alters_acc(op_e)) |=> $stable(acc_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hi_o <= '0;
      rd_lo_o <= '0;
      flag_o  <= 1'b0;
    end else begin
      if (fld_rd_en) begin
        rd_hi_o <= fld_rd_hi;
        rd_lo_o <= fld_rd_lo;
      end
      if (alu_flag_en) flag_o <= alu_flag_val;
    end
  end

  // R5: flag reflects the sign seen by abs
  assert_abs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_ABS) |=> flag_o == $past(cur[ACC_W-1]));

  // R5: flag holds for every other operation
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e != OP_ABS) |=> $stable(flag_o));

  // R10: low-word read
  assert_read_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_RLO) |=> (rd_lo_o == $past(cur[WORD_W-1:0])) && (rd_hi_o == '0));

  // R12: idle and unused codes hold the read outputs
  assert_idle_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 || op_i >= 4'd12) |=> $stable(rd_hi_o) && $stable(rd_lo_o));
endmodule

// File: tb/test_dual_acc40.sv
`timescale 1ns/1ps
module test_dual_acc40;
  localparam logic [3:0] C_IDLE = 4'd0, C_CLR = 4'd1, C_NEG = 4'd2, C_ABS = 4'd3,
                         C_WGRD = 4'd4, C_WHI = 4'd5, C_WLO = 4'd6, C_WPAIR = 4'd7,
                         C_RGRD = 4'd8, C_RHI = 4'd9, C_RLO = 4'd10, C_RPAIR = 4'd11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [0:0]  sel_i = '0;
  logic [15:0] reg_hi_i = '0, reg_lo_i = '0;
  logic        sat_en_i = 1'b0;
  logic [15:0] rd_hi_o, rd_lo_o;
  logic        flag_o;
  logic [79:0] acc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [39:0] m_acc [2];
  logic        m_flag;
  logic [15:0] m_rhi, m_rlo;

  always #2.5 clk = ~clk;

  dual_acc40 i_dual_acc40 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i),
    .reg_hi_i(reg_hi_i), .reg_lo_i(reg_lo_i), .sat_en_i(sat_en_i),
    .rd_hi_o(rd_hi_o), .rd_lo_o(rd_lo_o), .flag_o(flag_o), .acc_o(acc_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // signed arithmetic model: negate, wrap to 40 bits, then clamp
  function automatic logic [39:0] ref_negate(input logic [39:0] v, input bit sat);
    longint s, r;
    s = longint'({{24{v[39]}}, v});
    r = -s;
    if (r >= 64'sd549755813888) r = r - 64'sd1099511627776;
    if (sat) begin
      if (r > 64'sd2147483647)  r = 64'sd2147483647;
      if (r < -64'sd2147483648) r = -64'sd2147483648;
    end
    return r[39:0];
  endfunction

  function automatic logic [39:0] sx16(input logic [15:0] x);
    return {{24{x[15]}}, x};
  endfunction

  task automatic run_op(input logic [3:0] op, input logic sel,
                        input logic [15:0] hi, input logic [15:0] lo, input logic sat);
    string tag;
    logic [39:0] a;
    op_i = op; sel_i = sel; reg_hi_i = hi; reg_lo_i = lo; sat_en_i = sat;
    a = m_acc[sel];
    case (op)
      C_CLR:   begin tag = "R2"; m_acc[sel] = '0; end
      C_NEG:   begin tag = sat ? "R4" : "R3"; m_acc[sel] = ref_negate(a, sat); end
      C_ABS:   begin tag = (sat && a[39]) ? "R4" : "R5";
                     m_flag = a[39];
                     if (a[39]) m_acc[sel] = ref_negate(a, sat); end
      C_WGRD:  begin tag = "R6"; m_acc[sel] = {lo[7:0], a[31:0]}; end
      C_WHI:   begin tag = "R7"; m_acc[sel] = {sx16(lo)[23:0], a[15:0]}; end
      C_WLO:   begin tag = "R8"; m_acc[sel] = sx16(lo); end
      C_WPAIR: begin tag = "R9"; m_acc[sel] = {{8{hi[15]}}, hi, lo}; end
      C_RGRD:  begin tag = "R10"; m_rhi = 0; m_rlo = {8'h00, a[39:32]}; end
      C_RHI:   begin tag = "R10"; m_rhi = 0; m_rlo = a[31:16]; end
      C_RLO:   begin tag = "R10"; m_rhi = 0; m_rlo = a[15:0]; end
      C_RPAIR: begin tag = "R10"; m_rhi = a[31:16]; m_rlo = a[15:0]; end
      default: tag = "R12";
    endcase
    @(negedge clk);
    check(tag, "selected acc", {24'h0, acc_o[sel*40 +: 40]}, {24'h0, m_acc[sel]});
    check("R11", "other acc", {24'h0, acc_o[(1-sel)*40 +: 40]}, {24'h0, m_acc[1-sel]});
    check(tag, "flag", {63'h0, flag_o}, {63'h0, m_flag});
    check(tag, "rd_hi", {48'h0, rd_hi_o}, {48'h0, m_rhi});
    check(tag, "rd_lo", {48'h0, rd_lo_o}, {48'h0, m_rlo});
  endtask

  function automatic logic [15:0] pick_word();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_acc[0] = '0; m_acc[1] = '0; m_flag = 0; m_rhi = 0; m_rlo = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "acc0", {24'h0, acc_o[39:0]}, 64'h0);
    check("R1", "acc1", {24'h0, acc_o[79:40]}, 64'h0);
    check("R1", "flag", {63'h0, flag_o}, 64'h0);
    check("R1", "rd", {32'h0, rd_hi_o, rd_lo_o}, 64'h0);
    rst_n = 1'b1;

    // R4: -2^31 negated clamps to the positive limit, wraps to +2^31 without clamp
    run_op(C_WPAIR, 0, 16'h8000, 16'h0000, 0);
    run_op(C_NEG,   0, 16'h0,    16'h0,    1);
    run_op(C_WPAIR, 0, 16'h8000, 16'h0000, 0);
    run_op(C_NEG,   0, 16'h0,    16'h0,    0);
    // R3: +2^31 negates to -2^31 with no clamp, saturation on
    run_op(C_NEG,   0, 16'h0,    16'h0,    1);
    // R6 then R5/R4: 40-bit minimum under abs
    run_op(C_WGRD,  1, 16'h0,    16'h0080, 0);
    run_op(C_ABS,   1, 16'h0,    16'h0,    0);
    run_op(C_ABS,   1, 16'h0,    16'h0,    1);
    run_op(C_ABS,   1, 16'h0,    16'h0,    0);
    // R7 sign extension keeping low word, R10 reads
    run_op(C_WPAIR, 1, 16'h1234, 16'hABCD, 0);
    run_op(C_WHI,   1, 16'h0,    16'h9000, 0);
    run_op(C_RGRD,  1, 16'h0,    16'h0,    0);
    run_op(C_RPAIR, 1, 16'h0,    16'h0,    0);
    run_op(C_IDLE,  1, 16'hFFFF, 16'hFFFF, 1);
    run_op(4'd13,   0, 16'hFFFF, 16'hFFFF, 1);
    run_op(C_WLO,   0, 16'h0,    16'hFFFE, 0);
    run_op(C_RHI,   0, 16'h0,    16'h0,    0);
    run_op(C_CLR,   1, 16'h0,    16'h0,    0);

    for (int n = 0; n < 3000; n++)
      run_op(4'($urandom % 16), 1'($urandom % 2), pick_word(), pick_word(),
             1'($urandom % 2));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule